// File: doc/BRIEF.md
# Sensor Status Frame Builder

This block turns one set of sensor readings into a fixed status payload for a host link. When a trigger pulse arrives, it copies a 10-bit temperature word, eight 12-bit ADC channel words and an 8-bit slot location byte into a snapshot register. It then sends a 20-byte frame from that snapshot as a byte stream. The stream uses a valid/ready handshake and has markers for the first and the last byte. The Ethernet header, padding and the SPI sensor acquisition belong to neighbouring blocks.

Every sensor word goes out as a big-endian byte pair, padded with zeros at the top. The temperature comes first. The ADC channels follow, lowest channel first. A trigger that arrives while a frame is in flight is held as one pending request. That request starts a fresh frame on the cycle after the current last byte is accepted. The block does not stall the trigger source and adds no bubble between the two frames.

Top module: `status_frame_tx`

## Requirements
- R1: While reset is asserted and after it is released with no trigger, `tx_valid` and `busy` are low.
- R2: A trigger (`trig_i` high for one clock edge) while idle makes `tx_valid` high from the next cycle on. The first byte carries `tx_first` = 1 and equals the location byte `loc_i`.
- R3: Byte index 1 of every frame is the type code 0x53.
- R4: Byte 2 is {6'b0, temperature[9:8]} and byte 3 is temperature[7:0].
- R5: Bytes 4..19 carry ADC channel k at indices 4+2k (value {4'b0, adc[11:8]}) and 5+2k (value adc[7:0]), for k from 0 up to 7. Channel k is input bits `adc_i[12k+11:12k]`.
- R6: A frame is exactly 20 accepted bytes. `tx_last` is high only on byte 19 and `tx_first` only on byte 0, and the two are never high together.
- R7: The frame uses the input values from the clock edge that started it. Input changes after that edge do not alter the frame.
- R8: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` holds its value.
- R9: One or more triggers during a frame cause exactly one further frame. That frame starts in the cycle after byte 19 is accepted and is built from the inputs present at that acceptance edge.
- R10: `busy` equals `tx_valid` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Frame request pulse |
| loc_i | input | 8 | Slot location byte |
| temp_i | input | 10 | Temperature reading |
| adc_i | input | 96 | Eight 12-bit ADC readings, channel 0 in the low bits |
| tx_ready | input | 1 | Downstream can accept a byte |
| tx_valid | output | 1 | Byte on `tx_data` is offered |
| tx_data | output | 8 | Payload byte |
| tx_first | output | 1 | Offered byte is byte 0 of a frame |
| tx_last | output | 1 | Offered byte is byte 19 of a frame |
| busy | output | 1 | A frame is in flight |

## Verification
The bench builds the block with its default parameters: a 10-bit temperature and eight 12-bit channels, which gives a 20-byte frame. With these defaults every byte index can be reached, including both zero-padding patterns and the wrap from the last byte into a back-to-back frame. Readings of all ones and of alternating bit patterns show that the padding bits stay zero and that each channel lands at its own byte pair. Three downstream ready patterns (always ready, every other cycle, every third cycle) exercise the stall hold. A burst of triggers during a stalled frame checks that the requests merge into a single follow-up frame taken from fresh inputs.

// File: rtl/status_pkg.sv
package status_pkg;

    localparam int TEMP_W    = 10;
    localparam int ADC_W     = 12;
    localparam int ADC_CH    = 8;
    localparam int HDR_BYTES = 2;
    localparam int FRAME_LEN = HDR_BYTES + 2 + 2 * ADC_CH;
    localparam logic [7:0] TYPE_CODE = 8'h53;

    typedef struct packed {
        logic [7:0]                   loc;
        logic [TEMP_W-1:0]            temp;
        logic [ADC_CH-1:0][ADC_W-1:0] adc;
    } snap_t;

    // Upper or lower half of a zero-extended 16-bit word.
    function automatic logic [7:0] pair_half(input logic [15:0] w, input logic hi);
        return hi ? w[15:8] : w[7:0];
    endfunction

    function automatic logic [7:0] frame_byte(input snap_t s, input int unsigned pos);
        int unsigned ch;
        logic [15:0] w;
        w  = '0;
        ch = 0;
        if (pos == 0) begin
            return s.loc;
        end else if (pos == 1) begin
            return TYPE_CODE;
        end else if (pos < 4) begin
            w = 16'(s.temp);
            return pair_half(w, pos == 2);
        end else begin
            ch = (pos - 4) / 2;
            if (ch < ADC_CH) w = 16'(s.adc[ch]);
            return pair_half(w, ((pos - 4) % 2) == 0);
        end
    endfunction

endpackage

// File: rtl/status_snapshot.sv
module status_snapshot
    import status_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  snap_t din,
    output snap_t snap
);
    always_ff @(posedge clk) begin
        if (rst) snap <= '0;
        else if (load) snap <= din;
    end

    assert_snap_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(snap));
endmodule

// File: rtl/status_sequencer.sv
module status_sequencer #(
    parameter int FRAME_LEN = 20,
    localparam int IW = $clog2(FRAME_LEN)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          trig,
    input  logic          ready,
    output logic          active,
    output logic [IW-1:0] idx,
    output logic          load
);
    localparam logic [IW-1:0] LAST = IW'(FRAME_LEN - 1);

    logic pend;
    logic fin;

    assign fin  = active && ready && (idx == LAST);
    assign load = (trig && !active) || (fin && (pend || trig));

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            idx    <= '0;
            pend   <= 1'b0;
        end else if (load) begin
            active <= 1'b1;
            idx    <= '0;
            pend   <= 1'b0;
        end else begin
            if (fin) begin
                active <= 1'b0;
                idx    <= '0;
            end else if (active && ready) begin
                idx <= idx + 1'b1;
            end
            if (active && trig) pend <= 1'b1;
        end
    end

    assert_pend_in_frame_R9: assert property (@(posedge clk) disable iff (rst)
        pend |-> active);
    assert_idx_bound_R6: assert property (@(posedge clk) disable iff (rst)
        active |-> (idx <= LAST));
    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (active && !ready) |=> (active && $stable(idx)));
    assert_pend_handoff_R9: assert property (@(posedge clk) disable iff (rst)
        (fin && pend) |=> (active && idx == '0));
endmodule

// File: rtl/status_byte_mux.sv
module status_byte_mux
    import status_pkg::*;
#(
    parameter int FRAME_LEN = 20,
    localparam int IW = $clog2(FRAME_LEN)
) (
    input  snap_t         snap,
    input  logic [IW-1:0] idx,
    output logic [7:0]    data,
    output logic          first,
    output logic          last
);
    always_comb begin
        data  = frame_byte(snap, int'(idx));
        first = (idx == '0);
        last  = (idx == IW'(FRAME_LEN - 1));
    end
endmodule

// File: rtl/status_frame_tx.sv
module status_frame_tx
    import status_pkg::*;
#(
    parameter int N_CH  = ADC_CH,
    parameter int CH_W  = ADC_W,
    parameter int T_W   = TEMP_W,
    localparam int FLEN = HDR_BYTES + 2 + 2 * N_CH,
    localparam int IW   = $clog2(FLEN)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 trig_i,
    input  logic [7:0]           loc_i,
    input  logic [T_W-1:0]       temp_i,
    input  logic [N_CH*CH_W-1:0] adc_i,
    input  logic                 tx_ready,
    output logic                 tx_valid,
    output logic [7:0]           tx_data,
    output logic                 tx_first,
    output logic                 tx_last,
    output logic                 busy
);
    snap_t          din;
    snap_t          snap;
    logic           active;
    logic           load;
    logic [IW-1:0]  idx;
    logic           b_first;
    logic           b_last;

    always_comb begin
        din      = '0;
        din.loc  = loc_i;
        din.temp = TEMP_W'(temp_i);
        for (int k = 0; k < ADC_CH; k++) begin
            if (k < N_CH) din.adc[k] = ADC_W'(adc_i[k*CH_W +: CH_W]);
        end
    end

    status_snapshot u_snap (
        .clk (clk),
        .rst (rst),
        .load(load),
        .din (din),
        .snap(snap)
    );

    status_sequencer #(.FRAME_LEN(FLEN)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .trig  (trig_i),
        .ready (tx_ready),
        .active(active),
        .idx   (idx),
        .load  (load)
    );

    status_byte_mux #(.FRAME_LEN(FLEN)) u_mux (
        .snap (snap),
        .idx  (idx),
        .data (tx_data),
        .first(b_first),
        .last (b_last)
    );

    assign tx_valid = active;
    assign tx_first = active && b_first;
    assign tx_last  = active && b_last;
    assign busy     = active;

    assert_first_last_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(tx_first && tx_last));
    assert_data_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
    assert_last_then_gap_or_first_R9: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && tx_last) |=> (!tx_valid || tx_first));
endmodule

// File: tb/status_frame_tx_test.sv
module status_frame_tx_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trig_i = 1'b0;
    logic [7:0]  loc_i = '0;
    logic [9:0]  temp_i = '0;
    logic [95:0] adc_i = '0;
    logic        tx_ready = 1'b0;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_first;
    logic        tx_last;
    logic        busy;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    status_frame_tx uut (
        .clk(clk), .rst(rst), .trig_i(trig_i), .loc_i(loc_i), .temp_i(temp_i),
        .adc_i(adc_i), .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_first(tx_first), .tx_last(tx_last), .busy(busy)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int n, input logic [7:0] l,
                                            input logic [9:0] t, input logic [95:0] a);
        logic [11:0] v;
        if (n == 0) return l;
        if (n == 1) return 8'h53;
        if (n == 2) return {6'b0, t[9:8]};
        if (n == 3) return t[7:0];
        v = a[((n - 4) / 2) * 12 +: 12];
        if (n % 2 == 0) return {4'b0, v[11:8]};
        return v[7:0];
    endfunction

    function automatic string byte_tag(input int n);
        if (n == 0) return "R2";
        if (n == 1) return "R3";
        if (n < 4)  return "R4";
        return "R5";
    endfunction

    task automatic set_inputs(input logic [7:0] l, input logic [9:0] t, input logic [95:0] a);
        loc_i = l; temp_i = t; adc_i = a;
    endtask

    task automatic pulse_trig();
        @(negedge clk); trig_i = 1'b1;
        @(negedge clk); trig_i = 1'b0;
    endtask

    // Receive one frame; mode 0 always ready, 1 every other cycle, 2 every third cycle.
    task automatic recv(input logic [7:0] l, input logic [9:0] t, input logic [95:0] a,
                        input int mode);
        int n = 0;
        int cyc = 0;
        logic [7:0] held = '0;
        bit was_stall = 0;
        bit rdy;
        while (n < 20 && cyc < 200) begin
            @(negedge clk);
            cyc++;
            if (was_stall) check(tx_valid && tx_data == held, "R8 stall hold", tx_data, held);
            if (cyc == 1) check(tx_valid && tx_first, "R2 frame start", {tx_valid, tx_first}, 2'b11);
            check(busy == tx_valid, "R10 busy", busy, tx_valid);
            rdy = (mode == 0) ? 1'b1 : (mode == 1) ? cyc[0] : (cyc % 3 == 0);
            tx_ready = rdy;
            if (tx_valid && rdy) begin
                check(tx_data == exp_byte(n, l, t, a), byte_tag(n), tx_data, exp_byte(n, l, t, a));
                check(tx_last == (n == 19), "R6 last marker", tx_last, n == 19);
                check(tx_first == (n == 0), "R6 first marker", tx_first, n == 0);
                n++;
            end
            was_stall = tx_valid && !rdy;
            held = tx_data;
        end
        check(n == 20, "R6 frame length", n, 20);
    endtask

    task automatic expect_idle(input string tag);
        @(negedge clk);
        tx_ready = 1'b0;
        check(!tx_valid && !busy, tag, {tx_valid, busy}, 0);
    endtask

    task automatic t_reset();
        check(!tx_valid && !busy, "R1 in reset", {tx_valid, busy}, 0);
        @(negedge clk); rst = 1'b0; tx_ready = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check(!tx_valid && !busy, "R1 idle after reset", {tx_valid, busy}, 0);
        end
        tx_ready = 1'b0;
    endtask

    task automatic t_basic();
        logic [95:0] a;
        for (int k = 0; k < 8; k++) a[k*12 +: 12] = 12'h101 * (k + 1) + 12'h0A0;
        set_inputs(8'h3C, 10'h2B7, a);
        pulse_trig();
        recv(8'h3C, 10'h2B7, a, 0);
        expect_idle("R10 idle after frame");
    endtask

    task automatic t_extremes();
        set_inputs(8'hFF, 10'h3FF, {96{1'b1}});
        pulse_trig();
        recv(8'hFF, 10'h3FF, {96{1'b1}}, 0);
        expect_idle("R6 single frame");
        set_inputs(8'h00, 10'h155, {8{12'hA5A}});
        pulse_trig();
        recv(8'h00, 10'h155, {8{12'hA5A}}, 1);
        expect_idle("R6 single frame");
    endtask

    task automatic t_snapshot();
        logic [95:0] a;
        for (int k = 0; k < 8; k++) a[k*12 +: 12] = 12'(12'hF00 >> k) ^ 12'(k);
        set_inputs(8'h81, 10'h0C3, a);
        @(negedge clk); trig_i = 1'b1;
        @(negedge clk); trig_i = 1'b0;
        set_inputs(8'h7E, 10'h33C, ~a); // R7: changed after the start edge
        recv(8'h81, 10'h0C3, a, 2);
        expect_idle("R7 no extra frame");
    endtask

    task automatic t_pending();
        logic [95:0] a1;
        logic [95:0] a2;
        for (int k = 0; k < 8; k++) begin
            a1[k*12 +: 12] = 12'(k * 12'h111);
            a2[k*12 +: 12] = 12'(12'hFFF - k * 12'h0F1);
        end
        set_inputs(8'h11, 10'h201, a1);
        pulse_trig();
        // frame held stalled; two more triggers arrive (R9)
        pulse_trig();
        pulse_trig();
        check(tx_valid && tx_first, "R8 stalled start held", {tx_valid, tx_first}, 2'b11);
        set_inputs(8'h22, 10'h1FE, a2);
        recv(8'h11, 10'h201, a1, 1);
        recv(8'h22, 10'h1FE, a2, 0); // R9: back-to-back follow-up frame
        expect_idle("R9 only one follow-up frame");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_basic();
        t_extremes();
        t_snapshot();
        t_pending();
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule